// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This controller brings up and takes down the supply-rail groups of a large processor in a fixed, legal order. Each group is reduced to an enable output and a power-good input: a 1.8 V group (including the oscillator's analog supply), a core group, a DDR group (supply and reference), a row of compute-domain groups (processor, graphics, DSP, video accelerator), and a 3.3 V I/O group that includes the dual-voltage bank. Every step waits for the group it just switched to report good (or off, when powering down). A programmable timeout bounds each wait.

The chip-level power-on reset (active low) is held until every group is good and the main oscillator reports valid. After that the reset is held for a fixed number of extra cycles. On a shutdown request the reset is asserted first, and only then are groups removed. Power-down runs in one of two orders. The general order takes the domains down one at a time before core. The accelerated order takes domains, core and DDR down together. A timeout sets a sticky fault and runs the power-down order. A shutdown request during power-up aborts the ramp and backs out whatever was enabled.

Power-good and oscillator-valid are treated as asynchronous and pass through a synchronizer before the state machine sees them.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: During and after reset, all rail enables, `por_n`, `osc_en`, `done` and `fault` are 0.
- R2: Power-up enables the groups in this order: 1.8 V (bit 0), then core (bit 1) and DDR (bit 2) together with `osc_en`, then the domains, then I/O (bit NDOM+3). Each step starts only after every group enabled in the previous step reports good.
- R3: With STAGGER=1 the domains (bits 3 to NDOM+2) come up one per step in rising index order, and at most one domain enable rises in any cycle. With STAGGER=0 they come up together. No domain is ever enabled while core is disabled.
- R4: The I/O group enable is only ever high while the core enable is high.
- R5: `por_n` stays low until all groups are good and `osc_ok` is high. It then rises no earlier than HOLD_CYC cycles after that point, and `done` rises with it.
- R6: General power-down (`fast_pd`=0) follows this order: `por_n` falls; in the next cycle I/O and `osc_en` fall; then the domains go off one at a time from the highest index down; then core and DDR; then 1.8 V. Each step waits for the previous group's power-good to go low.
- R7: Accelerated power-down (`fast_pd`=1) follows this order: `por_n` falls; next I/O and `osc_en` fall; then all domains, core and DDR fall together; then 1.8 V.
- R8: No rail enable falls while `por_n` is high. `osc_en` falls only after `por_n` is low and while the 1.8 V group is still enabled.
- R9: A wait that exceeds `timeout_cycles` sets `fault` and runs the power-down order. `fault` is sticky, and once the sequence has finished, `start_req` has no effect until reset.
- R10: A `shut_req` during power-up aborts the ramp and removes only the groups already enabled, in power-down order. The block then returns to idle without a fault and can be started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to power up (taken in idle only) |
| shut_req | input | 1 | Request to power down or abort a ramp |
| fast_pd | input | 1 | 1 selects the accelerated power-down order |
| pg | input | NDOM+4 | Per-group power-good, asynchronous |
| osc_ok | input | 1 | Main oscillator valid, asynchronous |
| timeout_cycles | input | TW | Cycle limit for each wait |
| rail_en | output | NDOM+4 | Per-group rail enables |
| por_n | output | 1 | Chip power-on reset, active low |
| osc_en | output | 1 | Main oscillator enable |
| done | output | 1 | Sequence complete, all rails on |
| fault | output | 1 | Sticky timeout fault |

## Verification
The order of output changes is checked as a sequence of snapshots of enables, reset and oscillator enable, so every step is compared by order and not by exact cycle. Four patterns are used. A full power-up with a late oscillator and a general power-down separates the reset hold-off and the staggered reverse order. The same power-up with accelerated power-down shows the merged core step. A shutdown during the domain ramp checks that only enabled groups are backed out. A rail stuck low checks the timeout fault path and that start is then ignored.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  // Fixed group positions; domains start at GRP_DOM0, I/O follows the domains.
  localparam int GRP_18   = 0;
  localparam int GRP_CORE = 1;
  localparam int GRP_DDR  = 2;
  localparam int GRP_DOM0 = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RAMP_18,
    ST_RAMP_CORE,
    ST_RAMP_DOM,
    ST_RAMP_IO,
    ST_WAIT_OSC,
    ST_RELEASE,
    ST_ON,
    ST_PD_RST,
    ST_PD_IO,
    ST_PD_DOM,
    ST_PD_CORE,
    ST_PD_18,
    ST_FAULT
  } seq_state_t;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [TW-1:0] limit,
  output logic [TW-1:0] cnt,
  output logic          expired
);

  localparam logic [TW-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (cnt != CMAX)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  AST_TIMER_SAT: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == CMAX && !$past(clr)) |-> cnt == CMAX); // R9

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NDOM     = 4,
  parameter int TW       = 16,
  parameter int HOLD_CYC = 16,
  parameter bit STAGGER  = 1'b1,
  parameter int SYNC_STG = 2,
  localparam int NG      = NDOM + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          shut_req,
  input  logic          fast_pd,
  input  logic [NG-1:0] pg,
  input  logic          osc_ok,
  input  logic [TW-1:0] timeout_cycles,
  output logic [NG-1:0] rail_en,
  output logic          por_n,
  output logic          osc_en,
  output logic          done,
  output logic          fault
);

  localparam int DIW    = (NDOM > 1) ? $clog2(NDOM) : 1;
  localparam int GRP_IO = GRP_DOM0 + NDOM;
  localparam logic [NG-1:0] M18  = NG'(1) << GRP_18;
  localparam logic [NG-1:0] MCD  = (NG'(1) << GRP_CORE) | (NG'(1) << GRP_DDR);
  localparam logic [NG-1:0] MDOM = NG'((1 << NDOM) - 1) << GRP_DOM0;
  localparam logic [NG-1:0] MIO  = NG'(1) << GRP_IO;
  localparam logic [DIW-1:0] IDX_LAST = DIW'(NDOM - 1);

  seq_state_t state, nxt;
  logic [NG-1:0]  en_q, en_set, en_clr, dom_tgt, pg_s;
  logic [DIW-1:0] idx_q, idx_nx;
  logic           por_q, osc_q, done_q, fault_q, osc_s;
  logic           por_up, por_dn, osc_on, osc_off, flt, idx_mv, act;
  logic           pu_state, ok, tmo;
  logic [TW-1:0]  tcnt;

  pwr_seq_sync #(.W(NG + 1), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d({osc_ok, pg}), .q({osc_s, pg_s})
  );

  pwr_seq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .clr(act), .limit(timeout_cycles),
    .cnt(tcnt), .expired(tmo)
  );

  always_comb begin
    dom_tgt  = STAGGER ? (NG'(1) << (GRP_DOM0 + int'(idx_q))) : MDOM;
    pu_state = (state == ST_RAMP_18) || (state == ST_RAMP_CORE) ||
               (state == ST_RAMP_DOM) || (state == ST_RAMP_IO) ||
               (state == ST_WAIT_OSC) || (state == ST_RELEASE);
    unique case (state)
      ST_RAMP_18:   ok = (pg_s & M18) == M18;
      ST_RAMP_CORE: ok = (pg_s & MCD) == MCD;
      ST_RAMP_DOM:  ok = (pg_s & dom_tgt) == dom_tgt;
      ST_RAMP_IO:   ok = (pg_s & MIO) == MIO;
      ST_WAIT_OSC:  ok = osc_s;
      ST_RELEASE:   ok = (tcnt == TW'(HOLD_CYC - 1));
      ST_PD_IO:     ok = (pg_s & MIO) == '0;
      ST_PD_DOM:    ok = (pg_s & dom_tgt) == '0;
      ST_PD_CORE:   ok = (pg_s & (MCD | MDOM)) == '0;
      ST_PD_18:     ok = (pg_s & M18) == '0;
      default:      ok = 1'b0;
    endcase
  end

  always_comb begin
    nxt = state; en_set = '0; en_clr = '0; idx_nx = idx_q; idx_mv = 1'b0;
    por_up = 1'b0; por_dn = 1'b0; osc_on = 1'b0; osc_off = 1'b0; flt = 1'b0;
    if (pu_state && shut_req) begin
      nxt = ST_PD_RST; por_dn = 1'b1;
    end else if (pu_state && !ok && tmo && state != ST_RELEASE) begin
      nxt = ST_PD_RST; por_dn = 1'b1; flt = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (start_req && !shut_req) begin
          nxt = ST_RAMP_18; en_set = M18;
        end
        ST_RAMP_18: if (ok) begin
          nxt = ST_RAMP_CORE; en_set = MCD; osc_on = 1'b1;
        end
        ST_RAMP_CORE: if (ok) begin
          nxt = ST_RAMP_DOM; idx_nx = '0;
          en_set = STAGGER ? (NG'(1) << GRP_DOM0) : MDOM;
        end
        ST_RAMP_DOM: if (ok) begin
          if (STAGGER && idx_q != IDX_LAST) begin
            idx_nx = idx_q + 1'b1; idx_mv = 1'b1;
            en_set = NG'(1) << (GRP_DOM0 + int'(idx_q) + 1);
          end else begin
            nxt = ST_RAMP_IO; en_set = MIO;
          end
        end
        ST_RAMP_IO:  if (ok) nxt = ST_WAIT_OSC;
        ST_WAIT_OSC: if (ok) nxt = ST_RELEASE;
        ST_RELEASE:  if (ok) begin nxt = ST_ON; por_up = 1'b1; end
        ST_ON: if (shut_req) begin nxt = ST_PD_RST; por_dn = 1'b1; end
        ST_PD_RST: begin
          nxt = ST_PD_IO; en_clr = MIO; osc_off = 1'b1;
        end
        ST_PD_IO: if (ok || tmo) begin
          flt = !ok;
          if (fast_pd) begin
            nxt = ST_PD_CORE; en_clr = MDOM | MCD;
          end else begin
            nxt = ST_PD_DOM; idx_nx = IDX_LAST;
            en_clr = STAGGER ? (NG'(1) << (GRP_DOM0 + NDOM - 1)) : MDOM;
          end
        end
        ST_PD_DOM: if (ok || tmo) begin
          flt = !ok;
          if (STAGGER && idx_q != '0) begin
            idx_nx = idx_q - 1'b1; idx_mv = 1'b1;
            en_clr = NG'(1) << (GRP_DOM0 + int'(idx_q) - 1);
          end else begin
            nxt = ST_PD_CORE; en_clr = MCD;
          end
        end
        ST_PD_CORE: if (ok || tmo) begin
          flt = !ok; nxt = ST_PD_18; en_clr = M18;
        end
        ST_PD_18: if (ok || tmo) begin
          flt = !ok;
          nxt = (fault_q || !ok) ? ST_FAULT : ST_IDLE;
        end
        default: nxt = state;
      endcase
    end
    act = (nxt != state) || idx_mv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; en_q <= '0; idx_q <= '0;
      por_q <= 1'b0; osc_q <= 1'b0; done_q <= 1'b0; fault_q <= 1'b0;
    end else begin
      state   <= nxt;
      en_q    <= (en_q | en_set) & ~en_clr;
      idx_q   <= idx_nx;
      por_q   <= por_up | (por_q & ~por_dn);
      osc_q   <= osc_on | (osc_q & ~osc_off);
      done_q  <= (nxt == ST_ON);
      fault_q <= fault_q | flt;
    end
  end

  assign rail_en = en_q;
  assign por_n   = por_q;
  assign osc_en  = osc_q;
  assign done    = done_q;
  assign fault   = fault_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (en_q == '0 && !por_q && !osc_q && !done_q && !fault_q)); // R1

  AST_CORE_UNDER_DOM: assert property (@(posedge clk) disable iff (rst)
    ((en_q & MDOM) != '0) |-> en_q[GRP_CORE]); // R3

  AST_IO_UNDER_CORE: assert property (@(posedge clk) disable iff (rst)
    en_q[GRP_IO] |-> en_q[GRP_CORE]); // R4

  AST_RELEASE_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(por_q) |-> (en_q == '1 && (pg_s == '1) && osc_s && done_q)); // R5

  AST_NO_DROP_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    ((~en_q & $past(en_q)) != '0) |-> !$past(por_q)); // R8

  AST_OSC_OFF_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_q) |-> (!$past(por_q) && en_q[GRP_18])); // R8

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(fault_q) |-> fault_q); // R9

  generate
    if (STAGGER) begin : g_stag_chk
      AST_ONE_DOM_RISE: assert property (@(posedge clk) disable iff (rst)
        $countones(en_q & ~$past(en_q) & MDOM) <= 1); // R3
    end
  endgenerate

endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;

  localparam int NDOM = 4;
  localparam int NG   = NDOM + 4;
  localparam int TW   = 16;
  localparam int HOLD = 8;
  localparam int RDLY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0, shut_req = 1'b0, fast_pd = 1'b0, osc_ok = 1'b0;
  logic [TW-1:0] timeout_cycles = 16'd100;
  logic [NG-1:0] pg, rail_en, stuck;
  logic por_n, osc_en, done, fault;

  always #4 clk = ~clk;  // 125 MHz

  pwr_seq_ctrl #(.NDOM(NDOM), .TW(TW), .HOLD_CYC(HOLD), .STAGGER(1'b1)) dut (
    .clk(clk), .rst(rst), .start_req(start_req), .shut_req(shut_req),
    .fast_pd(fast_pd), .pg(pg), .osc_ok(osc_ok), .timeout_cycles(timeout_cycles),
    .rail_en(rail_en), .por_n(por_n), .osc_en(osc_en), .done(done), .fault(fault)
  );

  // Rail model: power-good follows enable after RDLY cycles unless stuck.
  int rc [NG];
  always @(posedge clk) begin
    for (int i = 0; i < NG; i++) begin
      if (rst) begin pg[i] <= 1'b0; rc[i] <= 0; end
      else if (stuck[i]) pg[i] <= 1'b0;
      else if (rail_en[i] != pg[i]) begin
        if (rc[i] >= RDLY) begin pg[i] <= rail_en[i]; rc[i] <= 0; end
        else rc[i] <= rc[i] + 1;
      end else rc[i] <= 0;
    end
  end

  int nchk = 0, nfail = 0;
  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct { logic [9:0] v; string tag; } exp_t;
  exp_t q[$];
  exp_t e;
  logic [9:0] last = '0, snap;

  task automatic push(logic [9:0] v, string tag);
    q.push_back('{v: v, tag: tag});
  endtask

  // Monitor: each change of {osc_en, por_n, rail_en} must match the next expected item.
  always @(negedge clk) begin
    if (!rst) begin
      snap = {osc_en, por_n, rail_en};
      if (snap !== last) begin
        last = snap;
        if (q.size() == 0) chk(1'b0, "unexpected change", 32'(snap), 32'h0);
        else begin
          e = q.pop_front();
          chk(snap === e.v, e.tag, 32'(snap), 32'(e.v));
        end
      end
    end
  end

  task automatic wait_snap(logic [9:0] v);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ({osc_en, por_n, rail_en} == v) return;
    end
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 3000 && q.size() != 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(q.size() == 0, tag, 32'(q.size()), 32'h0);
  endtask

  task automatic pulse_start();
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
  endtask

  task automatic pulse_shut();
    shut_req = 1'b1; @(negedge clk); shut_req = 1'b0;
  endtask

  task automatic push_rampup(string tag);
    push(10'h001, tag); push(10'h207, tag); push(10'h20F, tag);
    push(10'h21F, tag); push(10'h23F, tag); push(10'h27F, tag);
    push(10'h2FF, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int n;
    stuck = '0;
    repeat (5) @(negedge clk);
    chk(rail_en == '0 && !por_n && !osc_en && !done && !fault,
        "R1 reset outputs", {rail_en, por_n, osc_en, done, fault}, 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // A: full power-up with late oscillator, general power-down
    push_rampup("R2 R3 R4 power-up order");
    pulse_start();
    wait_snap(10'h2FF);
    repeat (40) @(negedge clk);
    chk(por_n == 1'b0, "R5 por held without osc_ok", 32'(por_n), 32'h0);
    push(10'h3FF, "R5 por release");
    osc_ok = 1'b1;
    n = 0;
    while (!por_n && n < 500) begin @(negedge clk); n++; end
    chk(n >= HOLD, "R5 hold-off length", 32'(n), 32'(HOLD));
    chk(done == 1'b1 && fault == 1'b0, "R5 done with release", {done, fault}, 32'h2);
    push(10'h2FF, "R6 por first"); push(10'h07F, "R6 io and osc off");
    push(10'h03F, "R6 dom3 off"); push(10'h01F, "R6 dom2 off");
    push(10'h00F, "R6 dom1 off"); push(10'h007, "R6 dom0 off");
    push(10'h001, "R6 core ddr off"); push(10'h000, "R6 1v8 off");
    pulse_shut();
    drain("R6 sequence complete");
    chk(done == 1'b0 && fault == 1'b0, "R6 idle flags", {done, fault}, 32'h0);

    // B: accelerated power-down
    fast_pd = 1'b1;
    push_rampup("R2 power-up again");
    push(10'h3FF, "R5 release");
    pulse_start();
    wait_snap(10'h3FF);
    push(10'h2FF, "R7 por first"); push(10'h07F, "R7 io and osc off");
    push(10'h001, "R7 dom core ddr together"); push(10'h000, "R7 1v8 off");
    pulse_shut();
    drain("R7 sequence complete");
    fast_pd = 1'b0;

    // C: abort during domain ramp
    push(10'h001, "R10 ramp"); push(10'h207, "R10 ramp"); push(10'h20F, "R10 ramp");
    push(10'h00F, "R10 io osc off"); push(10'h007, "R10 dom0 off");
    push(10'h001, "R10 core ddr off"); push(10'h000, "R10 1v8 off");
    pulse_start();
    wait_snap(10'h20F);
    pulse_shut();
    drain("R10 abort complete");
    chk(fault == 1'b0 && done == 1'b0, "R10 no fault", {done, fault}, 32'h0);

    // D: stuck domain 2 triggers timeout
    stuck[GRP_D2] = 1'b1;
    timeout_cycles = 16'd20;
    push(10'h001, "R9 ramp"); push(10'h207, "R9 ramp"); push(10'h20F, "R9 ramp");
    push(10'h21F, "R9 ramp"); push(10'h23F, "R9 ramp");
    push(10'h03F, "R9 io osc off"); push(10'h01F, "R9 dom2 off");
    push(10'h00F, "R9 dom1 off"); push(10'h007, "R9 dom0 off");
    push(10'h001, "R9 core ddr off"); push(10'h000, "R9 1v8 off");
    pulse_start();
    drain("R9 fault power-down");
    chk(fault == 1'b1 && done == 1'b0, "R9 fault set", {done, fault}, 32'h1);
    pulse_start();
    repeat (30) @(negedge clk);
    chk(rail_en == '0 && fault == 1'b1, "R9 start ignored in fault",
        {rail_en, fault}, 32'h1);

    rst = 1'b1; stuck = '0;
    repeat (3) @(negedge clk);
    chk(fault == 1'b0 && rail_en == '0, "R1 reset clears fault", {rail_en, fault}, 32'h0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  localparam int GRP_D2 = 5;

endmodule